// File: doc/BRIEF.md
# Indexed Drawing-Register Port with Command Queue

This block sits between a host bus and a 2D line-drawing engine. The host sees only two words. The word at offset 0 holds a register number. The word at offset 4 reads or writes whichever register that number selects. Writes to drawing registers do not take effect at once. Each one is stored as an (index, data) pair in a command queue. An internal engine drains the queue one entry per cycle, in order, and applies each entry to the live register set.

Applying a write to the line-end register takes a snapshot of the line endpoints, colours, write mask and clip corners. It presents that snapshot to the rasterizer with a request. The queue stalls until the rasterizer accepts the request.

A status word reports the number of free queue slots, a sticky overflow flag and a busy flag. Software can therefore check for space before it issues more commands. Status accesses and index-register accesses take effect at once and never pass through the queue.

Top module: `gfx_cmd_port`

## Requirements
- R1: A host write at offset 0 loads wdata[7:0] into the index register. A read at offset 0 returns the index in bits [7:0] with zeros above. A read at any offset other than 0 and 4 returns zero.
- R2: The drawing registers and their indices are:
  - 0x01: foreground colour
  - 0x02: background colour
  - 0x03: write mask
  - 0x04: line start
  - 0x05: line end
  - 0x06: clip top-left
  - 0x07: clip bottom-right

  A data write (offset 4) to one of them is queued. The queued writes are applied in arrival order. A read at offset 4 returns the applied value and never a value that is still queued.
- R3: Index 0x00 selects status. Bits [6:0] of status hold FIFO_DEPTH minus the queue occupancy, which is 64 when the queue is empty.
- R4: A data write to a non-status index while the queue is full is dropped and sets the sticky overflow bit, status bit 30. A data write to status with bit 30 set clears it. Bit 30 written as 0 leaves it unchanged.
- R5: Status bit 31 (busy) is 1 exactly when the queue is non-empty or a draw request is pending.
- R6: Applying a line-end entry raises draw_req on the next cycle. At the same time it drives the start, end, colour, mask and clip outputs with the register values that include that entry. These outputs and draw_req hold steady until a cycle with draw_ack high.
- R7: While draw_req is pending no queue entry is applied. Draining resumes in the cycle after the request is accepted.
- R8: Status writes never occupy a queue slot and never set the overflow bit, even when the queue is full.
- R9: After synchronous reset the index is 0, the queue is empty, overflow is 0, draw_req is 0 and all drawing registers read 0.
- R10: A data write to an index outside 0x00 to 0x07 occupies a slot and changes no register. A read of such an index returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sel | input | 1 | Host access strobe |
| host_wr | input | 1 | 1 for write, 0 for read |
| host_addr | input | 3 | Byte offset within the window (0 or 4) |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, combinational from offset and state |
| draw_req | output | 1 | Line draw request to the rasterizer |
| draw_ack | input | 1 | Rasterizer accepts the pending request |
| draw_start | output | 32 | Snapshot of line start |
| draw_end | output | 32 | Snapshot of line end |
| draw_fg | output | 32 | Snapshot of foreground colour |
| draw_bg | output | 32 | Snapshot of background colour |
| draw_mask | output | 32 | Snapshot of write mask |
| draw_clip_tl | output | 32 | Snapshot of clip top-left corner |
| draw_clip_br | output | 32 | Snapshot of clip bottom-right corner |

## Verification
The bench builds the block at its default depth of 64. This makes the full-queue boundary reachable: the free field reaches 0 and its largest value of 64. It also lets the bench hit the dropped-write and overflow-clear paths with a stalled draw.

A behavioural model built on a queue follows every host access and every acknowledge. Read data and the draw outputs are compared against it on every clock. Directed checks cover the following:
- the queued-versus-applied read;
- a draw held off by the acknowledge and then released;
- status writes while the queue is full;
- an acknowledge held high continuously.

// File: rtl/gfx_cmd_pkg.sv
package gfx_cmd_pkg;

    typedef logic [7:0]  reg_idx_t;
    typedef logic [31:0] word_t;

    // Register numbers seen through the index register
    localparam reg_idx_t RI_STATUS  = 8'h00;
    localparam reg_idx_t RI_FG      = 8'h01;
    localparam reg_idx_t RI_BG      = 8'h02;
    localparam reg_idx_t RI_MASK    = 8'h03;
    localparam reg_idx_t RI_START   = 8'h04;
    localparam reg_idx_t RI_STOP    = 8'h05;
    localparam reg_idx_t RI_CLIP_TL = 8'h06;
    localparam reg_idx_t RI_CLIP_BR = 8'h07;

    localparam int STAT_BUSY_BIT = 31;
    localparam int STAT_OVF_BIT  = 30;

    localparam logic [2:0] OFS_INDEX = 3'd0;
    localparam logic [2:0] OFS_DATA  = 3'd4;

    typedef struct packed {
        reg_idx_t idx;
        word_t    data;
    } cmd_t;

    typedef struct packed {
        word_t fg;
        word_t bg;
        word_t mask;
        word_t start;
        word_t stop;
        word_t clip_tl;
        word_t clip_br;
    } draw_regs_t;

    function automatic word_t read_reg(input draw_regs_t r, input reg_idx_t i);
        case (i)
            RI_FG:      return r.fg;
            RI_BG:      return r.bg;
            RI_MASK:    return r.mask;
            RI_START:   return r.start;
            RI_STOP:    return r.stop;
            RI_CLIP_TL: return r.clip_tl;
            RI_CLIP_BR: return r.clip_br;
            default:    return '0;
        endcase
    endfunction

    function automatic draw_regs_t apply_cmd(input draw_regs_t r, input cmd_t c);
        draw_regs_t n;
        n = r;
        case (c.idx)
            RI_FG:      n.fg      = c.data;
            RI_BG:      n.bg      = c.data;
            RI_MASK:    n.mask    = c.data;
            RI_START:   n.start   = c.data;
            RI_STOP:    n.stop    = c.data;
            RI_CLIP_TL: n.clip_tl = c.data;
            RI_CLIP_BR: n.clip_br = c.data;
            default:    n = r;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/gfx_cmd_fifo.sv
module gfx_cmd_fifo
    import gfx_cmd_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  cmd_t             push_data,
    input  logic             pop,
    output cmd_t             head,
    output logic             empty,
    output logic             full,
    output logic [CNT_W-1:0] count
);

    cmd_t             mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        if (p == PTR_W'(DEPTH - 1)) return '0;
        return p + 1'b1;
    endfunction

    assign empty = (count == '0);
    assign full  = (count == CNT_W'(DEPTH));
    assign head  = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    a_r3_count_range: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));
    a_r4_push_not_full: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);
    a_r2_pop_not_empty: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);

endmodule

// File: rtl/gfx_cmd_engine.sv
module gfx_cmd_engine
    import gfx_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  cmd_t       head,
    input  logic       empty,
    output logic       pop,
    output draw_regs_t live,
    output draw_regs_t snap,
    output logic       draw_req,
    input  logic       draw_ack
);

    draw_regs_t nxt;

    // One entry per cycle, none while a draw is outstanding
    assign pop = !empty && !draw_req;

    always_comb begin
        nxt = live;
        if (pop) nxt = apply_cmd(live, head);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            live     <= '0;
            snap     <= '0;
            draw_req <= 1'b0;
        end else begin
            live <= nxt;
            if (draw_req) begin
                if (draw_ack) draw_req <= 1'b0;
            end else if (pop && head.idx == RI_STOP) begin
                snap     <= nxt;
                draw_req <= 1'b1;
            end
        end
    end

    a_r6_req_hold: assert property (@(posedge clk) disable iff (rst)
        (draw_req && !draw_ack) |=> (draw_req && $stable(snap)));
    a_r6_req_after_stop: assert property (@(posedge clk) disable iff (rst)
        (!empty && !draw_req && head.idx == RI_STOP) |=> draw_req);
    a_r7_live_frozen: assert property (@(posedge clk) disable iff (rst)
        draw_req |=> $stable(live));

endmodule

// File: rtl/gfx_cmd_host.sv
module gfx_cmd_host
    import gfx_cmd_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             host_sel,
    input  logic             host_wr,
    input  logic [2:0]       host_addr,
    input  word_t            host_wdata,
    output word_t            host_rdata,
    input  logic             q_full,
    input  logic             q_empty,
    input  logic [CNT_W-1:0] q_count,
    input  draw_regs_t       live,
    input  logic             draw_req,
    output logic             push,
    output cmd_t             push_data
);

    reg_idx_t idx_q;
    logic     ovf_q;
    logic     wr_index;
    logic     wr_data;
    logic     to_status;
    word_t    status;

    assign wr_index  = host_sel && host_wr && (host_addr == OFS_INDEX);
    assign wr_data   = host_sel && host_wr && (host_addr == OFS_DATA);
    assign to_status = (idx_q == RI_STATUS);

    assign push           = wr_data && !to_status && !q_full;
    assign push_data.idx  = idx_q;
    assign push_data.data = host_wdata;

    always_comb begin
        status                = '0;
        status[STAT_BUSY_BIT] = !q_empty || draw_req;
        status[STAT_OVF_BIT]  = ovf_q;
        status[CNT_W-1:0]     = CNT_W'(DEPTH) - q_count;
    end

    always_comb begin
        case (host_addr)
            OFS_INDEX: host_rdata = {24'd0, idx_q};
            OFS_DATA:  host_rdata = to_status ? status : read_reg(live, idx_q);
            default:   host_rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= RI_STATUS;
            ovf_q <= 1'b0;
        end else begin
            if (wr_index) idx_q <= host_wdata[7:0];
            if (wr_data && !to_status && q_full)
                ovf_q <= 1'b1;
            else if (wr_data && to_status && host_wdata[STAT_OVF_BIT])
                ovf_q <= 1'b0;
        end
    end

    a_r1_index_load: assert property (@(posedge clk) disable iff (rst)
        wr_index |=> (idx_q == $past(host_wdata[7:0])));
    a_r4_drop_sets_ovf: assert property (@(posedge clk) disable iff (rst)
        (wr_data && !to_status && q_full) |=> ovf_q);
    a_r4_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        (ovf_q && !(wr_data && to_status && host_wdata[STAT_OVF_BIT])) |=> ovf_q);
    a_r8_status_no_slot: assert property (@(posedge clk) disable iff (rst)
        (wr_data && to_status) |-> !push);

endmodule

// File: rtl/gfx_cmd_port.sv
module gfx_cmd_port
    import gfx_cmd_pkg::*;
#(
    parameter int FIFO_DEPTH = 64,
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        host_sel,
    input  logic        host_wr,
    input  logic [2:0]  host_addr,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata,
    output logic        draw_req,
    input  logic        draw_ack,
    output logic [31:0] draw_start,
    output logic [31:0] draw_end,
    output logic [31:0] draw_fg,
    output logic [31:0] draw_bg,
    output logic [31:0] draw_mask,
    output logic [31:0] draw_clip_tl,
    output logic [31:0] draw_clip_br
);

    cmd_t             push_data;
    cmd_t             head;
    logic             push;
    logic             pop;
    logic             q_empty;
    logic             q_full;
    logic [CNT_W-1:0] q_count;
    draw_regs_t       live;
    draw_regs_t       snap;

    gfx_cmd_host #(.DEPTH(FIFO_DEPTH)) u_host (
        .clk        (clk),
        .rst        (rst),
        .host_sel   (host_sel),
        .host_wr    (host_wr),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .q_full     (q_full),
        .q_empty    (q_empty),
        .q_count    (q_count),
        .live       (live),
        .draw_req   (draw_req),
        .push       (push),
        .push_data  (push_data)
    );

    gfx_cmd_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .push_data (push_data),
        .pop       (pop),
        .head      (head),
        .empty     (q_empty),
        .full      (q_full),
        .count     (q_count)
    );

    gfx_cmd_engine u_engine (
        .clk      (clk),
        .rst      (rst),
        .head     (head),
        .empty    (q_empty),
        .pop      (pop),
        .live     (live),
        .snap     (snap),
        .draw_req (draw_req),
        .draw_ack (draw_ack)
    );

    assign draw_start   = snap.start;
    assign draw_end     = snap.stop;
    assign draw_fg      = snap.fg;
    assign draw_bg      = snap.bg;
    assign draw_mask    = snap.mask;
    assign draw_clip_tl = snap.clip_tl;
    assign draw_clip_br = snap.clip_br;

    // R7: a stalled draw never lets the queue shrink
    a_r7_queue_held: assert property (@(posedge clk) disable iff (rst)
        (draw_req && !draw_ack) |=> (q_count >= $past(q_count)));
    a_r5_busy_when_queued: assert property (@(posedge clk) disable iff (rst)
        (!q_empty && host_addr == OFS_DATA && u_host.idx_q == RI_STATUS)
        |-> host_rdata[STAT_BUSY_BIT]);

endmodule

// File: tb/gfx_cmd_port_bench.sv
module gfx_cmd_port_bench;

    localparam int DEPTH = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_sel = 1'b0;
    logic        host_wr = 1'b0;
    logic [2:0]  host_addr = 3'd0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        draw_req;
    logic        draw_ack = 1'b0;
    logic [31:0] draw_start, draw_end, draw_fg, draw_bg, draw_mask, draw_clip_tl, draw_clip_br;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    gfx_cmd_port #(.FIFO_DEPTH(DEPTH)) u_gfx_cmd_port (
        .clk(clk), .rst(rst), .host_sel(host_sel), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .draw_req(draw_req), .draw_ack(draw_ack), .draw_start(draw_start),
        .draw_end(draw_end), .draw_fg(draw_fg), .draw_bg(draw_bg),
        .draw_mask(draw_mask), .draw_clip_tl(draw_clip_tl), .draw_clip_br(draw_clip_br)
    );

    always #10 clk = ~clk;

    // ---------------- behavioural reference model ----------------
    logic [39:0] m_q[$];
    logic [7:0]  m_idx;
    logic        m_ovf;
    logic        m_req;
    logic [31:0] m_reg[8];
    logic [31:0] m_snap[8];

    always @(posedge clk) begin
        if (rst) begin
            m_q.delete();
            m_idx = 8'd0; m_ovf = 1'b0; m_req = 1'b0;
            for (int i = 0; i < 8; i++) begin m_reg[i] = '0; m_snap[i] = '0; end
        end else begin
            automatic bit full = (m_q.size() == DEPTH);
            if (m_req) begin
                if (draw_ack) m_req = 1'b0;
            end else if (m_q.size() > 0) begin
                automatic logic [39:0] e = m_q.pop_front();
                automatic int ix = int'(e[39:32]);
                if (ix >= 1 && ix <= 7) m_reg[ix] = e[31:0];
                if (ix == 5) begin
                    for (int i = 0; i < 8; i++) m_snap[i] = m_reg[i];
                    m_req = 1'b1;
                end
            end
            if (host_sel && host_wr) begin
                if (host_addr == 3'd0) m_idx = host_wdata[7:0];
                else if (host_addr == 3'd4) begin
                    if (m_idx == 8'd0) begin
                        if (host_wdata[30]) m_ovf = 1'b0;
                    end else if (full) m_ovf = 1'b1;
                    else m_q.push_back({m_idx, host_wdata});
                end
            end
        end
    end

    function automatic logic [31:0] model_rdata(input logic [2:0] a);
        logic [31:0] s;
        if (a == 3'd0) return {24'd0, m_idx};
        if (a != 3'd4) return '0;
        if (m_idx == 8'd0) begin
            s = '0;
            s[31] = (m_q.size() > 0) || m_req;
            s[30] = m_ovf;
            s[6:0] = 7'(DEPTH - m_q.size());
            return s;
        end
        if (m_idx <= 8'd7) return m_reg[m_idx];
        return '0;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // compare every clock, 5 ns after the rising edge
    always @(posedge clk) begin
        #5;
        if (!rst && !done) begin
            check("R2 R3 R5 model rdata", host_rdata, model_rdata(host_addr));
            check("R6 R7 model draw_req", {31'd0, draw_req}, {31'd0, m_req});
            check("R6 model draw_start", draw_start, m_snap[4]);
            check("R6 model draw_end", draw_end, m_snap[5]);
            check("R6 model draw_fg", draw_fg, m_snap[1]);
            check("R6 model draw_bg", draw_bg, m_snap[2]);
            check("R6 model draw_mask", draw_mask, m_snap[3]);
            check("R6 model draw_clip", draw_clip_tl ^ {draw_clip_br[15:0], draw_clip_br[31:16]},
                  m_snap[6] ^ {m_snap[7][15:0], m_snap[7][31:16]});
        end
    end

    // ---------------- stimulus helpers (called at a falling edge) ----------------
    task automatic host_write(input logic [2:0] a, input logic [31:0] d);
        host_sel = 1'b1; host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_sel = 1'b0; host_wr = 1'b0;
    endtask

    task automatic host_read(input logic [2:0] a, input string tag, input logic [31:0] exp);
        host_sel = 1'b1; host_wr = 1'b0; host_addr = a;
        #2;
        check(tag, host_rdata, exp);
        @(negedge clk);
        host_sel = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        rst = 1'b0;
        // R9 reset state, R3 free count
        host_read(3'd0, "R9 index after reset", 32'd0);
        host_read(3'd4, "R9 R3 status after reset", 32'd64);
        check("R9 draw_req after reset", {31'd0, draw_req}, 32'd0);

        // R1 index readback, R2 queued vs applied
        host_write(3'd0, 32'hFFFF_FF01);
        host_read(3'd0, "R1 index readback", 32'h0000_0001);
        host_read(3'd2, "R1 unused offset reads zero", 32'd0);
        host_write(3'd4, 32'hAABB_CCDD);
        host_read(3'd4, "R2 queued value not yet visible", 32'd0);
        host_read(3'd4, "R2 applied foreground", 32'hAABB_CCDD);

        host_write(3'd0, 32'd2); host_write(3'd4, 32'h1111_2222);
        host_write(3'd0, 32'd3); host_write(3'd4, 32'h00FF_00FF);
        host_write(3'd0, 32'd4); host_write(3'd4, 32'h0010_0020);
        host_write(3'd0, 32'd6); host_write(3'd4, 32'h0000_0000);
        host_write(3'd0, 32'd7); host_write(3'd4, 32'h02FF_03FF);
        // R6 line end issues a draw; ack held low
        host_write(3'd0, 32'd5); host_write(3'd4, 32'h0040_0080);
        idle(3);
        check("R6 draw_req raised", {31'd0, draw_req}, 32'd1);
        check("R6 draw_start snapshot", draw_start, 32'h0010_0020);
        check("R6 draw_end snapshot", draw_end, 32'h0040_0080);
        check("R6 draw_fg snapshot", draw_fg, 32'hAABB_CCDD);

        // R7 new entry waits behind the pending draw
        host_write(3'd0, 32'd1); host_write(3'd4, 32'h5555_6666);
        idle(3);
        host_read(3'd4, "R7 foreground not applied while stalled", 32'hAABB_CCDD);
        host_write(3'd0, 32'd0);
        host_read(3'd4, "R5 R3 status busy with one queued", 32'h8000_003F);
        draw_ack = 1'b1; @(negedge clk); draw_ack = 1'b0;
        check("R6 draw_req dropped after ack", {31'd0, draw_req}, 32'd0);
        idle(2);
        host_read(3'd4, "R5 R7 status idle after drain", 32'd64);
        host_write(3'd0, 32'd1);
        host_read(3'd4, "R7 foreground applied after ack", 32'h5555_6666);

        // R4 fill the queue behind a stalled draw
        host_write(3'd0, 32'd5); host_write(3'd4, 32'h0001_0001);
        idle(3);
        host_write(3'd0, 32'd2);
        for (int i = 0; i < DEPTH; i++) host_write(3'd4, 32'h100 + i);
        host_write(3'd0, 32'd0);
        host_read(3'd4, "R3 R5 status full", 32'h8000_0000);
        host_write(3'd0, 32'd2);
        host_write(3'd4, 32'hDEAD_BEEF);
        host_write(3'd0, 32'd0);
        host_read(3'd4, "R4 overflow set by dropped write", 32'hC000_0000);
        host_write(3'd4, 32'h0000_0000);
        host_read(3'd4, "R4 R8 zero write keeps overflow, no slot", 32'hC000_0000);
        host_write(3'd4, 32'h4000_0000);
        host_read(3'd4, "R4 R8 overflow cleared, still full", 32'h8000_0000);

        // drain with ack held high
        draw_ack = 1'b1;
        idle(DEPTH + 8);
        host_read(3'd4, "R3 R5 status after full drain", 32'd64);
        host_write(3'd0, 32'd2);
        host_read(3'd4, "R2 last queued background wins, dropped lost", 32'h100 + DEPTH - 1);

        // R6 immediate acceptance, R10 unmapped index
        host_write(3'd0, 32'd5); host_write(3'd4, 32'h0123_0456);
        idle(4);
        check("R6 end after immediate accept", draw_end, 32'h0123_0456);
        check("R6 req gone after immediate accept", {31'd0, draw_req}, 32'd0);
        host_write(3'd0, 32'h40); host_write(3'd4, 32'h7777_7777);
        host_read(3'd4, "R10 unmapped index reads zero", 32'd0);
        idle(3);
        host_write(3'd0, 32'd1);
        host_read(3'd4, "R10 unmapped write left foreground", 32'h5555_6666);
        draw_ack = 1'b0;
        idle(3);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule